// File: doc/BRIEF.md
# ADC configure-and-read serial sequencer

This block is the master side of a four-wire serial link to a converter whose behaviour is set through a command-addressed configuration register. After reset it puts the converter into a mode with two data lines and 16 clocks per frame. The converter still expects the long power-up frame at this point, so that first write uses 32 clocks. The sequencer can then read the configuration register back to confirm the write. A register read needs two frames of 48 clocks each: the first carries the read command and the second returns the register contents. Once the configuration is confirmed, the block runs short 16-clock frames that collect one result word from each of the two data lines.

Every command word is 16 bits. The top four bits are an opcode and the low twelve bits are a value. The serial clock idles low. The block drives the command line on rising serial-clock edges, MSB first, and samples both data lines on falling edges. A programmable divider sets the length of each serial-clock half period. A host raises `start` to request conversion frames. Results come back on two 16-bit outputs together with a one-cycle strobe. If the readback does not match the value that was written, the block halts with an error flag and runs no more frames.

The controller moves through six named states. CFG_WR sends the boot-format write. RB_CMD sends the readback command. RB_DATA fetches the register contents and compares them. READY waits for `start`. CONV runs one conversion frame. FAIL halts. Each of these transitions happens when the frame engine reports that the current frame is complete:
- CFG_WR to RB_CMD (or to READY when `VERIFY` is 0).
- RB_CMD to RB_DATA.
- RB_DATA to READY on a match, or to FAIL on a mismatch.
- CONV to CONV while `start` is held, or to READY when it is not.

READY moves to CONV when `start` is high.

Top module: `adcseq_top`

## Requirements
- R1: The first frame after reset holds `cs_n` low for exactly 32 falling `sclk` edges. Its first 16 bits on `din` are `CFG_WORD` (default 16'h8800, opcode 4'b1000 in bits 15:12), and the remaining bits are 0.
- R2: `sclk` is low whenever `cs_n` is high. `din` changes only in the cycle in which `sclk` rises.
- R3: When `VERIFY` is 1, the second frame has exactly 48 falling edges and sends 16'h3000 (opcode 4'b0011, value 12'h000), followed by zeros.
- R4: The third frame has exactly 48 falling edges and sends all zeros. The first 16 bits captured from `sdo_a` form the readback word. Only its bits 11:0 are compared with `CFG_WORD[11:0]`, and bits 15:12 are ignored.
- R5: On a match, `cfg_ok` rises and `cfg_error` stays low. On a mismatch, `cfg_error` rises and stays high until reset, `cfg_ok` stays low, and no further frame starts even if `start` is high.
- R6: Configuration and readback frames never produce `res_valid`.
- R7: A conversion frame has exactly 16 falling edges and sends all zeros on `din`. A frame starts only while `start` is high in READY. One frame follows another for as long as `start` is still high when a frame completes.
- R8: After each conversion frame, `res_a` and `res_b` hold the 16 bits sampled from `sdo_a` and `sdo_b` (first bit is the MSB). `res_valid` pulses for exactly one cycle while `cs_n` is high.
- R9: `cs_n` stays high for at least two clock cycles between frames. The first `sclk` rise comes exactly `HALF` cycles after `cs_n` falls.
- R10: Every `sclk` high and low phase inside a frame lasts exactly `HALF` system clocks.
- R11: During reset, `cs_n`=1, `sclk`=0, `din`=0, and `res_valid`, `cfg_ok` and `cfg_error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Requests conversion frames while high |
| sdo_a | input | 1 | Converter data line A |
| sdo_b | input | 1 | Converter data line B |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| din | output | 1 | Command data to the converter |
| res_a | output | 16 | Last result word from line A |
| res_b | output | 16 | Last result word from line B |
| res_valid | output | 1 | One-cycle strobe for new results |
| cfg_ok | output | 1 | Configuration readback matched |
| cfg_error | output | 1 | Configuration readback mismatched |

## Verification
The readback path is run with four returned words:
- An exact match.
- A match whose upper four bits are all ones, which shows that the opcode nibble is ignored.
- Two single-bit errors in the value field, one fixed and one random, which show that every value bit takes part in the compare.

Conversion frames carry random words on both data lines, and each frame uses different words, so swapped lines, shifted bits or stale captures show up as wrong results. `start` is driven in random-length held bursts and in isolated one-cycle pulses. The bursts check back-to-back framing and the stop after `start` falls. The pulses check that exactly one frame follows each request.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int WORD_W   = 16;
    localparam int OP_W     = 4;
    localparam int VAL_W    = WORD_W - OP_W;
    localparam int LEN_W    = 6;

    localparam logic [OP_W-1:0] OP_NOP    = 4'b0000;
    localparam logic [OP_W-1:0] OP_RD_CFG = 4'b0011;
    localparam logic [OP_W-1:0] OP_WR_CFG = 4'b1000;

    localparam logic [LEN_W-1:0] LEN_BOOT = 6'd32;
    localparam logic [LEN_W-1:0] LEN_REG  = 6'd48;
    localparam logic [LEN_W-1:0] LEN_CONV = 6'd16;

    typedef enum logic [2:0] {
        T_CFG_WR,
        T_RB_CMD,
        T_RB_DATA,
        T_READY,
        T_CONV,
        T_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_LEAD,
        E_HI,
        E_LO,
        E_TRAIL,
        E_GAP
    } eng_state_t;

    function automatic logic [WORD_W-1:0] mk_cmd(logic [OP_W-1:0] op, logic [VAL_W-1:0] val);
        return {op, val};
    endfunction

endpackage

// File: rtl/adcseq_div.sv
module adcseq_div #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (HALF <= 1) begin : g_direct
            assign tick = en;
        end else begin : g_count
            logic [DW-1:0] cnt;
            assign tick = en && (cnt == DW'(HALF - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!en || tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + DW'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
    import adcseq_pkg::*;
#(
    parameter int HALF = 2,
    parameter int GAP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LEN_W-1:0]  nclk,
    input  logic [WORD_W-1:0] tx,
    input  logic              sdo_a,
    input  logic              sdo_b,
    output logic              cs_n,
    output logic              sclk,
    output logic              din,
    output logic [WORD_W-1:0] cap_a,
    output logic [WORD_W-1:0] cap_b,
    output logic              done,
    output logic              idle
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

    eng_state_t        st, st_nx;
    logic              tick;
    logic              en;
    logic [LEN_W-1:0]  edges;
    logic [LEN_W-1:0]  nclk_q;
    logic [WORD_W-1:0] txsr;
    logic [GW-1:0]     gcnt;
    logic              gap_end;

    assign en      = (st == E_LEAD) || (st == E_HI) || (st == E_LO) || (st == E_TRAIL);
    assign idle    = (st == E_IDLE);
    assign gap_end = (st == E_GAP) && (gcnt == GW'(GAP - 1));

    adcseq_div #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .tick (tick)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            E_IDLE:  if (go)      st_nx = E_LEAD;
            E_LEAD:  if (tick)    st_nx = E_HI;
            E_HI:    if (tick)    st_nx = ((edges + LEN_W'(1)) == nclk_q) ? E_TRAIL : E_LO;
            E_LO:    if (tick)    st_nx = E_HI;
            E_TRAIL: if (tick)    st_nx = E_GAP;
            E_GAP:   if (gap_end) st_nx = E_IDLE;
            default:              st_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            din    <= 1'b0;
            edges  <= '0;
            nclk_q <= '0;
            txsr   <= '0;
            gcnt   <= '0;
            cap_a  <= '0;
            cap_b  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                E_IDLE: begin
                    if (go) begin
                        cs_n   <= 1'b0;
                        nclk_q <= nclk;
                        txsr   <= tx;
                        edges  <= '0;
                    end
                end
                E_LEAD, E_LO: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        din  <= txsr[WORD_W-1];
                        txsr <= {txsr[WORD_W-2:0], 1'b0};
                    end
                end
                E_HI: begin
                    if (tick) begin
                        sclk  <= 1'b0;
                        edges <= edges + LEN_W'(1);
                        if (edges < LEN_W'(WORD_W)) begin
                            cap_a <= {cap_a[WORD_W-2:0], sdo_a};
                            cap_b <= {cap_b[WORD_W-2:0], sdo_b};
                        end
                    end
                end
                E_TRAIL: begin
                    if (tick) begin
                        cs_n <= 1'b1;
                        gcnt <= '0;
                    end
                end
                E_GAP: begin
                    gcnt <= gcnt + GW'(1);
                    if (gap_end) done <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int              HALF     = 2,
    parameter int              GAP      = 2,
    parameter logic [15:0]     CFG_WORD = 16'h8800,
    parameter bit              VERIFY   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        sdo_a,
    input  logic        sdo_b,
    output logic        cs_n,
    output logic        sclk,
    output logic        din,
    output logic [15:0] res_a,
    output logic [15:0] res_b,
    output logic        res_valid,
    output logic        cfg_ok,
    output logic        cfg_error
);
    localparam logic [WORD_W-1:0] CMD_RD  = mk_cmd(OP_RD_CFG, '0);
    localparam logic [WORD_W-1:0] CMD_NOP = mk_cmd(OP_NOP, '0);

    seq_state_t        st, st_nx;
    logic              sent;
    logic              go;
    logic              eng_done;
    logic              eng_idle;
    logic [LEN_W-1:0]  nclk;
    logic [WORD_W-1:0] tx;
    logic [WORD_W-1:0] cap_a, cap_b;
    logic              match;
    logic              framing;

    assign match   = (cap_a[VAL_W-1:0] == CFG_WORD[VAL_W-1:0]);
    assign framing = (st == T_CFG_WR) || (st == T_RB_CMD) || (st == T_RB_DATA) || (st == T_CONV);
    assign go      = framing && eng_idle && !sent;

    always_comb begin
        unique case (st)
            T_CFG_WR:  begin tx = CFG_WORD; nclk = LEN_BOOT; end
            T_RB_CMD:  begin tx = CMD_RD;   nclk = LEN_REG;  end
            T_RB_DATA: begin tx = CMD_NOP;  nclk = LEN_REG;  end
            default:   begin tx = CMD_NOP;  nclk = LEN_CONV; end
        endcase
    end

    adcseq_frame #(.HALF(HALF), .GAP(GAP)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .nclk (nclk),
        .tx   (tx),
        .sdo_a(sdo_a),
        .sdo_b(sdo_b),
        .cs_n (cs_n),
        .sclk (sclk),
        .din  (din),
        .cap_a(cap_a),
        .cap_b(cap_b),
        .done (eng_done),
        .idle (eng_idle)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            T_CFG_WR:  if (eng_done) st_nx = VERIFY ? T_RB_CMD : T_READY;
            T_RB_CMD:  if (eng_done) st_nx = T_RB_DATA;
            T_RB_DATA: if (eng_done) st_nx = match ? T_READY : T_FAIL;
            T_READY:   if (start)    st_nx = T_CONV;
            T_CONV:    if (eng_done) st_nx = start ? T_CONV : T_READY;
            T_FAIL:                  st_nx = T_FAIL;
            default:                 st_nx = T_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_CFG_WR;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent      <= 1'b0;
            res_a     <= '0;
            res_b     <= '0;
            res_valid <= 1'b0;
            cfg_ok    <= 1'b0;
            cfg_error <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (go)       sent <= 1'b1;
            if (eng_done) sent <= 1'b0;
            if (eng_done) begin
                unique case (st)
                    T_CFG_WR:  if (!VERIFY) cfg_ok <= 1'b1;
                    T_RB_DATA: begin
                        if (match) cfg_ok    <= 1'b1;
                        else       cfg_error <= 1'b1;
                    end
                    T_CONV: begin
                        res_a     <= cap_a;
                        res_b     <= cap_b;
                        res_valid <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic din,
    input logic res_valid,
    input logic cfg_ok,
    input logic cfg_error
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R2
    AST_DIN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) !$rose(sclk) |-> $stable(din)); // R2
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cfg_error |-> cs_n); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_error |=> cfg_error); // R5
    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_ok && cfg_error)); // R5
    AST_VALID_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> cfg_ok); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R8
    AST_VALID_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> cs_n); // R8
    AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n); // R9

    generate
        if (HALF > 1) begin : g_half
            AST_SCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |=> sclk); // R10
            AST_SCLK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |=> !sclk); // R10
        end
    endgenerate
endmodule

bind adcseq_top adcseq_chk #(.HALF(HALF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .din      (din),
    .res_valid(res_valid),
    .cfg_ok   (cfg_ok),
    .cfg_error(cfg_error)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sdo_a = 1'b0;
    logic        sdo_b = 1'b0;
    logic        cs_n, sclk, din, res_valid, cfg_ok, cfg_error;
    logic [15:0] res_a, res_b;

    always #2 clk = ~clk;

    adcseq_top #(.HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sdo_a(sdo_a), .sdo_b(sdo_b),
        .cs_n(cs_n), .sclk(sclk), .din(din), .res_a(res_a), .res_b(res_b),
        .res_valid(res_valid), .cfg_ok(cfg_ok), .cfg_error(cfg_error)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(int f);
        if (f == 0) return 32;
        if (f < 3)  return 48;
        return 16;
    endfunction

    function automatic logic [15:0] exp_cmd(int f);
        if (f == 0) return 16'h8800;
        if (f == 1) return 16'h3000;
        return 16'h0000;
    endfunction

    function automatic string frame_req(int f);
        if (f == 0) return "R1";
        if (f == 1) return "R3";
        if (f == 2) return "R4";
        return "R7";
    endfunction

    logic [15:0] rb_word = 16'h0800;
    int          fi, edges, ivl, gap;
    bit          first, pending, dextra;
    logic [15:0] dword, wa, wb, oa, ob, la, lb;
    logic        prev_cs, prev_sclk, prev_din, prev_valid;

    always @(negedge clk) begin
        if (!rst_n) begin
            fi = 0; pending = 0; gap = 0; first = 1; edges = 0; ivl = 0;
            prev_cs = 1; prev_sclk = 0; prev_din = 0; prev_valid = 0;
            sdo_a = 0; sdo_b = 0;
        end else begin
            if (cs_n && sclk) check(0, "R2", "sclk high with cs_n high", 1, 0);
            if (din !== prev_din && !(sclk && !prev_sclk))
                check(0, "R2", "din changed away from a rising edge", din, prev_din);
            if (!cs_n && prev_cs) begin
                if (!first) check(gap >= 2, "R9", "cs_n high time", gap, 2);
                first = 0; edges = 0; ivl = 0; dword = 0; dextra = 0;
                wa = (fi == 2) ? rb_word : 16'($urandom);
                wb = 16'($urandom);
                oa = wa; ob = wb;
                sdo_a = wa[15]; sdo_b = wb[15];
            end else if (!cs_n) begin
                ivl++;
                if (sclk != prev_sclk) begin
                    if (edges == 0 && sclk) check(ivl == HALF, "R9", "cs_n fall to first sclk rise", ivl, HALF);
                    else check(ivl == HALF, "R10", "sclk phase length", ivl, HALF);
                    ivl = 0;
                    if (!sclk) begin
                        edges++;
                        if (edges <= 16) dword = {dword[14:0], din};
                        else if (din) dextra = 1;
                        wa = {wa[14:0], 1'b0}; wb = {wb[14:0], 1'b0};
                        sdo_a = wa[15]; sdo_b = wb[15];
                    end
                end
            end
            if (cs_n && !prev_cs) begin
                check(edges == exp_len(fi), frame_req(fi), "falling edges in frame", edges, exp_len(fi));
                check(dword == exp_cmd(fi) && !dextra, frame_req(fi), "command word on din", dword, exp_cmd(fi));
                if (fi >= 3) begin pending = 1; la = oa; lb = ob; end
                fi++;
                gap = 0;
            end
            if (cs_n) gap++;
            if (res_valid) begin
                check(pending, "R6", "result strobe without conversion frame", 1, 0);
                check(res_a == la, "R8", "res_a", res_a, la);
                check(res_b == lb, "R8", "res_b", res_b, lb);
                check(!prev_valid, "R8", "strobe longer than one cycle", 1, 0);
                pending = 0;
            end
            prev_cs = cs_n; prev_sclk = sclk; prev_din = din; prev_valid = res_valid;
        end
    end

    task automatic do_reset(logic [15:0] rb);
        start = 0;
        rb_word = rb;
        rst_n = 0;
        repeat (4) @(negedge clk);
        check(cs_n && !sclk && !din && !res_valid && !cfg_ok && !cfg_error, "R11", "reset outputs",
              {cs_n, sclk, din, res_valid, cfg_ok, cfg_error}, 6'b100000);
        rst_n = 1;
    endtask

    task automatic wait_cfg();
        for (int t = 0; t < 8000 && !cfg_ok && !cfg_error; t++) @(negedge clk);
    endtask

    task automatic good_run(logic [15:0] rb, int bursts, int pulses);
        int f0, f1, n;
        do_reset(rb);
        wait_cfg();
        check(cfg_ok && !cfg_error, "R5", "readback accepted", {cfg_ok, cfg_error}, 2'b10);
        check(fi == 3, "R4", "frames before ready", fi, 3);
        repeat (150) @(negedge clk);
        check(fi == 3, "R7", "no conversion frame without start", fi, 3);
        for (int b = 0; b < bursts; b++) begin
            n = 2 + int'($urandom % 5);
            f0 = fi;
            start = 1;
            while (fi < f0 + n) @(negedge clk);
            start = 0;
            repeat (150) @(negedge clk);
            f1 = fi;
            check(f1 >= f0 + n, "R7", "back-to-back frames while start held", f1, f0 + n);
            repeat (200) @(negedge clk);
            check(fi == f1, "R7", "frames stop after start falls", fi, f1);
            check(!pending, "R8", "every conversion frame reported", pending, 0);
        end
        for (int p = 0; p < pulses; p++) begin
            repeat (5 + int'($urandom % 40)) @(negedge clk);
            f0 = fi;
            start = 1;
            @(negedge clk);
            start = 0;
            repeat (200) @(negedge clk);
            check(fi == f0 + 1, "R7", "one frame per one-cycle start", fi, f0 + 1);
        end
    endtask

    task automatic bad_run(logic [15:0] rb);
        do_reset(rb);
        wait_cfg();
        start = 1;
        repeat (600) @(negedge clk);
        check(cfg_error && !cfg_ok, "R5", "readback mismatch flagged", {cfg_ok, cfg_error}, 2'b01);
        check(fi == 3, "R5", "no frame after mismatch", fi, 3);
        check(cs_n, "R5", "bus idle after mismatch", cs_n, 1);
        start = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        good_run(16'h0800, 4, 5);
        good_run(16'hF800, 1, 2);
        bad_run(16'h0801);
        bad_run(16'h0800 ^ (16'h1 << ($urandom % 12)));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual %0d expected %0d cycles", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule